// File: doc/BRIEF.md
# Deferred Virtual Error Record Register

This block is a 64-bit status register. It keeps a record of a virtual asynchronous error that a barrier instruction has absorbed while it was pending for the lower privileged level. When the deferral pulse arrives, the register sets its valid flag. In the same cycle it fills its syndrome fields in one of three layouts.

The layout-select input chooses between two kinds of record:
- The syndrome layout copies an implementation-defined bit and a 24-bit syndrome value from the pending-syndrome inputs.
- The fault-status layout copies the error-type and external-abort fields from the same inputs. It also writes a fixed fault code.

In the fault-status layout, the extended-address-enable input picks the encoding. With the input low, the short-descriptor encoding is used. With the input high, the long-descriptor encoding is used.

Software at the higher privilege levels can read and write the register directly. Two ordering rules apply:
- A read that happens in the same cycle as a deferral already returns the new record. This means software needs no extra synchronization after the barrier.
- A software write in the same cycle as a deferral wins over the deferral.

Top module: `vderr_record`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the stored value is all zeros and rd_data_o reads 0 while no deferral is applied.
- R2: Bits 63:32 of rd_data_o always read 0. A write with ones in bits 63:32 leaves those bits at 0.
- R3: A deferral pulse (defer_i high at an edge, wr_en_i low) sets bit 31 (valid) of the stored value to 1.
- R4: With layout_i = 0 (syndrome layout), a deferral stores these fields:
  - pend_ids_i at bit 24.
  - pend_iss_i at bits 23:0.
  - 1 at bit 31.
  - 0 in every other bit.
- R5: With layout_i = 1 and eae_i = 0 (short format), a deferral stores these fields. The 5-bit fault code is 0b10110, split as a high bit at bit 10 and a low nibble at bits 3:0.
  - 1 at bit 31.
  - pend_aet_i at bits 15:14.
  - pend_ext_i at bit 12.
  - 1 at bit 10.
  - 0 at bit 9 (format bit).
  - 0b0110 at bits 3:0.
  - 0 in all other bits.
- R6: With layout_i = 1 and eae_i = 1 (long format), a deferral stores these fields:
  - 1 at bit 31.
  - pend_aet_i at bits 15:14.
  - pend_ext_i at bit 12.
  - 1 at bit 9 (format bit).
  - 0b010001 at bits 5:0.
  - 0 in all other bits.
- R7: In a cycle with defer_i high, rd_data_o already shows the record being captured, combinationally. After the edge, that record is the stored value.
- R8: A software write (wr_en_i high) stores wr_data_i ANDed with a field mask chosen by the layout inputs at the time of the write:
  - 0x81FFFFFF for the syndrome layout.
  - 0x8000D60F for the short format.
  - 0x8000D23F for the long format.

  A write takes priority over a deferral in the same cycle.
- R9: With neither defer_i nor wr_en_i high, the stored value holds unchanged. Changes on the pending-syndrome inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| defer_i | input | 1 | Barrier absorbed a pending virtual error (one-cycle pulse) |
| layout_i | input | 1 | 0: syndrome layout, 1: fault-status layout |
| eae_i | input | 1 | Extended-address enable; selects long (1) or short (0) fault format |
| pend_ids_i | input | 1 | Pending syndrome: implementation-defined syndrome bit |
| pend_iss_i | input | 24 | Pending syndrome: syndrome value |
| pend_aet_i | input | 2 | Pending syndrome: error type |
| pend_ext_i | input | 1 | Pending syndrome: external abort type |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 64 | Software write data |
| rd_data_o | output | 64 | Read value, forwarding a same-cycle capture |

## Verification
The capture is driven in each of the three layouts. Each uses pending-syndrome values with alternating and all-ones bit patterns, so a field placed at the wrong position or copied from the wrong input shows up.

Short and long captures are run with the same error-type and external-abort inputs, so only the fixed fault code and the format bit tell them apart.

All-ones software writes in each layout expose the field mask and the upper-half masking. A write coinciding with a deferral separates the correct priority from the reverse. Idle cycles with toggling syndrome inputs catch a register that reloads when it should hold.

// File: rtl/vderr_pkg.sv
// Package: shared constants for the deferred virtual error record.
// Assumes the architected half of the record is the low 32 bits.
package vderr_pkg;

    localparam int LOW_W    = 32;
    localparam int ISS_W    = 24;
    localparam int AET_W    = 2;

    // Bit positions decoded by software
    localparam int VALID_B  = 31;
    localparam int IDS_B    = 24;
    localparam int AET_LO   = 14;
    localparam int EXT_B    = 12;
    localparam int FSHI_B   = 10;
    localparam int FMT_B    = 9;

    // Fixed fault codes
    localparam logic [4:0] SHORT_CODE = 5'b10110;
    localparam logic [5:0] LONG_CODE  = 6'b010001;

    // Writable field masks per layout
    localparam logic [LOW_W-1:0] MASK_SYND  = 32'h81FF_FFFF;
    localparam logic [LOW_W-1:0] MASK_SHORT = 32'h8000_D60F;
    localparam logic [LOW_W-1:0] MASK_LONG  = 32'h8000_D23F;

    typedef enum logic {
        LAYOUT_SYND  = 1'b0,
        LAYOUT_FAULT = 1'b1
    } layout_e;

endpackage

// File: rtl/vderr_capture.sv
// Module: vderr_capture
// Builds the record word written on a deferral, from the layout inputs and
// the pending-syndrome fields. Purely combinational. Assumes REG_W >= 32.
module vderr_capture
    import vderr_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             layout_i,
    input  logic             eae_i,
    input  logic             ids_i,
    input  logic [ISS_W-1:0] iss_i,
    input  logic [AET_W-1:0] aet_i,
    input  logic             ext_i,
    output logic [REG_W-1:0] word_o
);

    logic [LOW_W-1:0] low;

    // Assemble the low half field by field for the selected layout
    always_comb begin
        low = '0;
        low[VALID_B] = 1'b1;
        if (layout_e'(layout_i) == LAYOUT_SYND) begin
            low[IDS_B]       = ids_i;
            low[ISS_W-1:0]   = iss_i;
        end else begin
            low[AET_LO+AET_W-1:AET_LO] = aet_i;
            low[EXT_B]                 = ext_i;
            low[FMT_B]                 = eae_i;
            if (eae_i) begin
                low[5:0] = LONG_CODE;
            end else begin
                low[FSHI_B] = SHORT_CODE[4];
                low[3:0]    = SHORT_CODE[3:0];
            end
        end
    end

    // Upper half is reserved and always zero
    always_comb begin
        word_o = '0;
        word_o[LOW_W-1:0] = low;
    end

endmodule

// File: rtl/vderr_wmask.sv
// Module: vderr_wmask
// Masks software write data down to the fields defined by the current
// layout. Bits above the low 32 are cleared. Assumes REG_W >= 32.
module vderr_wmask
    import vderr_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             layout_i,
    input  logic             eae_i,
    input  logic [REG_W-1:0] data_i,
    output logic [REG_W-1:0] data_o
);

    logic [LOW_W-1:0] mask;

    // Choose the field mask for the active layout
    always_comb begin
        if (layout_e'(layout_i) == LAYOUT_SYND) mask = MASK_SYND;
        else if (eae_i)                         mask = MASK_LONG;
        else                                    mask = MASK_SHORT;
    end

    // Apply the mask and clear the reserved upper half
    always_comb begin
        data_o = '0;
        data_o[LOW_W-1:0] = data_i[LOW_W-1:0] & mask;
    end

endmodule

// File: rtl/vderr_store.sv
// Module: vderr_store
// Holds the record. A write beats a capture in the same cycle. The read
// port forwards a same-cycle capture so no synchronization is needed.
module vderr_store #(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic [REG_W-1:0] cap_word_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_word_i,
    output logic [REG_W-1:0] q_o,
    output logic [REG_W-1:0] rd_o
);

    // Update the stored record: reset, then write, then capture
    always_ff @(posedge clk) begin
        if (!rst_n)        q_o <= '0;
        else if (wr_en_i)  q_o <= wr_word_i;
        else if (cap_en_i) q_o <= cap_word_i;
    end

    // Read path with capture forwarding
    always_comb begin
        rd_o = cap_en_i ? cap_word_i : q_o;
    end

endmodule

// File: rtl/vderr_record.sv
// Module: vderr_record (top)
// Deferred virtual error record register. It captures a record on a
// deferral pulse and offers direct software read and write.
// Assumes defer_i is a single-cycle pulse per absorbed error and that
// REG_W >= 32.
module vderr_record
    import vderr_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             defer_i,
    input  logic             layout_i,
    input  logic             eae_i,
    input  logic             pend_ids_i,
    input  logic [ISS_W-1:0] pend_iss_i,
    input  logic [AET_W-1:0] pend_aet_i,
    input  logic             pend_ext_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o
);

    logic [REG_W-1:0] cap_word;
    logic [REG_W-1:0] wr_word;
    logic [REG_W-1:0] rec_q;

    vderr_capture #(.REG_W(REG_W)) i_capture (
        .layout_i (layout_i),
        .eae_i    (eae_i),
        .ids_i    (pend_ids_i),
        .iss_i    (pend_iss_i),
        .aet_i    (pend_aet_i),
        .ext_i    (pend_ext_i),
        .word_o   (cap_word)
    );

    vderr_wmask #(.REG_W(REG_W)) i_wmask (
        .layout_i (layout_i),
        .eae_i    (eae_i),
        .data_i   (wr_data_i),
        .data_o   (wr_word)
    );

    vderr_store #(.REG_W(REG_W)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (defer_i),
        .cap_word_i (cap_word),
        .wr_en_i    (wr_en_i),
        .wr_word_i  (wr_word),
        .q_o        (rec_q),
        .rd_o       (rd_data_o)
    );

endmodule

// File: rtl/vderr_record_chk.sv
// Module: vderr_record_chk
// Assertion checker bound to vderr_record. It observes the ports and the
// stored record.
module vderr_record_chk #(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             defer_i,
    input logic             wr_en_i,
    input logic             wr_bit31_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic [REG_W-1:0] rec_q
);

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> rec_q == '0);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[REG_W-1:32] == '0);

    a_r3_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        defer_i && !wr_en_i |=> rec_q[31]);

    a_r7_forward: assert property (@(posedge clk) disable iff (!rst_n)
        defer_i && !wr_en_i |=> rec_q == $past(rd_data_o));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && defer_i |=> rec_q[31] == $past(wr_bit31_i));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !defer_i && !wr_en_i |=> $stable(rec_q));

endmodule

bind vderr_record vderr_record_chk #(.REG_W(REG_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .defer_i    (defer_i),
    .wr_en_i    (wr_en_i),
    .wr_bit31_i (wr_data_i[31]),
    .rd_data_o  (rd_data_o),
    .rec_q      (rec_q)
);

// File: tb/test_vderr_record.sv
// Directed bench for vderr_record. Inputs are driven at the falling edge
// and results are sampled 1 ns later.
module test_vderr_record;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        defer_i, layout_i, eae_i, pend_ids_i, pend_ext_i, wr_en_i;
    logic [23:0] pend_iss_i;
    logic [1:0]  pend_aet_i;
    logic [63:0] wr_data_i;
    logic [63:0] rd_data_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    vderr_record i_vderr_record (
        .clk(clk), .rst_n(rst_n), .defer_i(defer_i), .layout_i(layout_i),
        .eae_i(eae_i), .pend_ids_i(pend_ids_i), .pend_iss_i(pend_iss_i),
        .pend_aet_i(pend_aet_i), .pend_ext_i(pend_ext_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input string req, input logic [63:0] exp);
        n_checks++;
        if (rd_data_o !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, rd_data_o, exp);
        end
    endtask

    function automatic logic [63:0] exp_synd(input logic ids, input logic [23:0] iss);
        return 64'h8000_0000 | (64'(ids) << 24) | 64'(iss);
    endfunction

    function automatic logic [63:0] exp_short(input logic [1:0] aet, input logic ext);
        return 64'h8000_0000 | (64'(aet) << 14) | (64'(ext) << 12) | 64'h400 | 64'h6;
    endfunction

    function automatic logic [63:0] exp_long(input logic [1:0] aet, input logic ext);
        return 64'h8000_0000 | (64'(aet) << 14) | (64'(ext) << 12) | 64'h200 | 64'h11;
    endfunction

    task automatic idle_inputs();
        defer_i = 0; wr_en_i = 0; wr_data_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle_inputs();
        @(negedge clk);
        rst_n = 1;
    endtask

    // Capture one record; check forwarding in-cycle and the stored value after
    task automatic defer_once(input string req, input logic lay, input logic eae,
                              input logic ids, input logic [23:0] iss,
                              input logic [1:0] aet, input logic ext,
                              input logic [63:0] exp);
        @(negedge clk);
        layout_i = lay; eae_i = eae; pend_ids_i = ids; pend_iss_i = iss;
        pend_aet_i = aet; pend_ext_i = ext; defer_i = 1;
        #1 check({req, " R7 forward"}, exp);
        @(negedge clk);
        defer_i = 0;
        #1 check({req, " stored"}, exp);
    endtask

    task automatic t_reset();
        do_reset();
        #1 check("R1 reset zero", 64'h0);
    endtask

    task automatic t_syndrome();
        do_reset();
        defer_once("R4 R3 synd a", 1'b0, 1'b1, 1'b1, 24'hA5A5A5, 2'b11, 1'b1,
                   exp_synd(1'b1, 24'hA5A5A5));
        defer_once("R4 synd b", 1'b0, 1'b0, 1'b0, 24'h5A5A5A, 2'b00, 1'b0,
                   exp_synd(1'b0, 24'h5A5A5A));
    endtask

    task automatic t_short();
        do_reset();
        defer_once("R5 R3 short a", 1'b1, 1'b0, 1'b1, 24'hFFFFFF, 2'b10, 1'b1,
                   exp_short(2'b10, 1'b1));
        defer_once("R5 short b", 1'b1, 1'b0, 1'b0, 24'h0, 2'b01, 1'b0,
                   exp_short(2'b01, 1'b0));
    endtask

    task automatic t_long();
        do_reset();
        defer_once("R6 long a", 1'b1, 1'b1, 1'b1, 24'hFFFFFF, 2'b10, 1'b1,
                   exp_long(2'b10, 1'b1));
        defer_once("R6 long b", 1'b1, 1'b1, 1'b0, 24'h0, 2'b01, 1'b0,
                   exp_long(2'b01, 1'b0));
    endtask

    task automatic write_once(input string req, input logic lay, input logic eae,
                              input logic [63:0] data, input logic [63:0] exp);
        @(negedge clk);
        layout_i = lay; eae_i = eae; wr_en_i = 1; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 0; wr_data_i = '0;
        #1 check(req, exp);
    endtask

    task automatic t_writes();
        do_reset();
        write_once("R8 R2 synd mask", 1'b0, 1'b0, '1, 64'h0000_0000_81FF_FFFF);
        write_once("R8 R2 short mask", 1'b1, 1'b0, '1, 64'h0000_0000_8000_D60F);
        write_once("R8 R2 long mask", 1'b1, 1'b1, '1, 64'h0000_0000_8000_D23F);
        write_once("R2 upper only", 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0);
    endtask

    task automatic t_priority();
        do_reset();
        @(negedge clk);
        layout_i = 0; eae_i = 0; pend_ids_i = 1; pend_iss_i = 24'h123456;
        defer_i = 1; wr_en_i = 1; wr_data_i = 64'h0000_0000_0000_00C3;
        @(negedge clk);
        defer_i = 0; wr_en_i = 0; wr_data_i = '0;
        #1 check("R8 write beats defer", 64'h0000_0000_0000_00C3);
    endtask

    task automatic t_hold();
        do_reset();
        defer_once("R9 setup", 1'b1, 1'b1, 1'b0, 24'h0, 2'b11, 1'b1,
                   exp_long(2'b11, 1'b1));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pend_iss_i = 24'(i * 24'h111111); pend_aet_i = 2'(i);
            pend_ext_i = ~pend_ext_i; layout_i = ~layout_i; eae_i = ~eae_i;
        end
        #1 check("R9 hold", exp_long(2'b11, 1'b1));
    endtask

    initial begin
        rst_n = 0; layout_i = 0; eae_i = 0; pend_ids_i = 0; pend_iss_i = '0;
        pend_aet_i = '0; pend_ext_i = 0; idle_inputs();
        t_reset();
        t_syndrome();
        t_short();
        t_long();
        t_writes();
        t_priority();
        t_hold();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule